// File: doc/BRIEF.md
# Bus Hold Acknowledge Controller

This controller hands the address and data buses of a small processor core to an external DMA master. The master raises an asynchronous request; the controller brings it into the system clock domain, arms an internal hold latch, and raises acknowledge at a point that depends on the kind of machine cycle in progress. The buses are then released on the next phase2 edge. The core is frozen only once its current machine cycle has run to completion, so internal states can overlap the external transfer.

Everything runs on one system clock. Two non-overlapping enables, phase1 and phase2, mark the edges on which the controller acts. At each phase1 edge, `mstate_i` names the machine state that begins at that edge, and `cyc_end_i` tells whether the state that ends there was the last one of its machine cycle. When the request is withdrawn, acknowledge falls on the next phase1 edge and the core resumes with the following machine cycle. The buses stay floated until the phase2 edge after that, so the two masters never drive at the same time.

Top module: `bus_hold_ctrl`

## Requirements
- R1: The request passes through a two-flop synchronizer. The hold latch sets only on a phase2 edge where the synchronized request and `ready_i` are both high. While `ready_i` stays low, acknowledge never rises.
- R2: In a read or input cycle (`rd_cyc_i`=1), acknowledge rises on the phase1 edge where `mstate_i` is T3 (code 2), provided the latch is set.
- R3: In any other cycle, acknowledge rises on the phase1 edge that follows the one which began a non-read T3. That edge starts T4 (code 3) or the next cycle's T1 (code 0).
- R4: `bus_float_o` rises on the first phase2 edge after acknowledge rises, stays high while acknowledge is high, and falls on the first phase2 edge after acknowledge falls.
- R5: `bus_float_o` is never high unless acknowledge is high or has fallen since the last phase2 edge.
- R6: `core_freeze_o` rises only while acknowledge is high, on the phase1 edge that closes the current machine cycle (`cyc_end_i`=1) or that sees the halt state. The core keeps stepping through T4 and T5 until then.
- R7: When the synchronized request is low at a phase1 edge, acknowledge and freeze fall together on that edge.
- R8: A request pulse that is gone before any phase2 edge samples it as synchronized has no effect: acknowledge stays low.
- R9: In the halt state (code 6), a latched hold is acknowledged on the next phase1 edge. After release the core remains in halt.
- R10: An asynchronous active-low reset clears the synchronizer, latch, acknowledge, freeze and float at once.
- R11: Acknowledge and freeze change only on phase1 edges. Float changes only on phase2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ph1_en_i | input | 1 | Phase1 edge enable |
| ph2_en_i | input | 1 | Phase2 edge enable |
| hold_req_i | input | 1 | Asynchronous bus hold request |
| ready_i | input | 1 | Memory ready |
| mstate_i | input | 3 | State starting at this phase1 edge (T1..T5 = 0..4, wait = 5, halt = 6) |
| rd_cyc_i | input | 1 | Current machine cycle is a read or input cycle |
| cyc_end_i | input | 1 | The state ending at this phase1 edge closes its machine cycle |
| hold_ack_o | output | 1 | Hold acknowledge |
| bus_float_o | output | 1 | Address and data buses floated |
| core_freeze_o | output | 1 | Core stopped for the hold |

## Verification
Acknowledge and freeze can rise on the same phase1 edge. This happens when a deferred acknowledge lands on a cycle boundary, as in a three-state write whose T3 is also its last state, and it also happens in halt. The bench provokes both cases: it runs write programs of three and four states and a halt program while the request is held. The cycle-accurate model judges each edge, and a monitor checks that every freeze rise coincides with either a cycle end or the halt state.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic [2:0] {
    ST_T1   = 3'd0,
    ST_T2   = 3'd1,
    ST_T3   = 3'd2,
    ST_T4   = 3'd3,
    ST_T5   = 3'd4,
    ST_WAIT = 3'd5,
    ST_HALT = 3'd6
  } mstate_e;
  localparam int unsigned MSTATE_W = 3;
endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_rest
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bhc_hold_latch.sv
module bhc_hold_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph2_en_i,
  input  logic req_sync_i,
  input  logic ready_i,
  output logic latch_o
);
  logic latch_q;

  // sets with request and ready; stays while request stays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       latch_q <= 1'b0;
    else if (ph2_en_i) latch_q <= req_sync_i & (ready_i | latch_q);
  end

  assign latch_o = latch_q;

  // R1
  latch_set_on_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(ph2_en_i) && $past(ready_i) && $past(req_sync_i));
endmodule

// File: rtl/bhc_ack_ctrl.sv
module bhc_ack_ctrl
  import bhc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ph1_en_i,
  input  logic                req_sync_i,
  input  logic                latch_i,
  input  logic [MSTATE_W-1:0] mstate_i,
  input  logic                rd_cyc_i,
  input  logic                cyc_end_i,
  output logic                ack_o,
  output logic                freeze_o
);
  mstate_e st;
  logic    ack_q, ack_d, frz_q, frz_d;
  logic    after_t3_q;   // previous phase1 edge began a non-read T3
  logic    grant_pt;

  assign st = mstate_e'(mstate_i);

  always_comb begin
    grant_pt = (st == ST_T3 && rd_cyc_i) || after_t3_q || (st == ST_HALT);
    ack_d    = ack_q ? req_sync_i : (latch_i & grant_pt);
    frz_d    = ack_d & (frz_q | cyc_end_i | (st == ST_HALT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      frz_q      <= 1'b0;
      after_t3_q <= 1'b0;
    end else if (ph1_en_i) begin
      ack_q      <= ack_d;
      frz_q      <= frz_d;
      after_t3_q <= (st == ST_T3) && !rd_cyc_i;
    end
  end

  assign ack_o    = ack_q;
  assign freeze_o = frz_q;

  // R11
  ack_only_ph1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph1_en_i |=> $stable(ack_q) && $stable(frz_q));
  // R6
  freeze_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_q |-> ack_q);
  // R7
  release_on_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_en_i && ack_q && !req_sync_i |=> !ack_q && !frz_q);
endmodule

// File: rtl/bhc_bus_float.sv
module bhc_bus_float (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph2_en_i,
  input  logic ack_i,
  output logic float_o
);
  logic float_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       float_q <= 1'b0;
    else if (ph2_en_i) float_q <= ack_i;
  end

  assign float_o = float_q;

  // R4
  float_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(float_q) |-> ack_i);
  // R11
  float_only_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph2_en_i |=> $stable(float_q));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ph1_en_i,
  input  logic                ph2_en_i,
  input  logic                hold_req_i,
  input  logic                ready_i,
  input  logic [MSTATE_W-1:0] mstate_i,
  input  logic                rd_cyc_i,
  input  logic                cyc_end_i,
  output logic                hold_ack_o,
  output logic                bus_float_o,
  output logic                core_freeze_o
);
  logic req_sync, latch, ack, frz, flt;

  bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hold_req_i), .q_o(req_sync)
  );

  bhc_hold_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph2_en_i(ph2_en_i),
    .req_sync_i(req_sync), .ready_i(ready_i), .latch_o(latch)
  );

  bhc_ack_ctrl u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph1_en_i(ph1_en_i),
    .req_sync_i(req_sync), .latch_i(latch), .mstate_i(mstate_i),
    .rd_cyc_i(rd_cyc_i), .cyc_end_i(cyc_end_i),
    .ack_o(ack), .freeze_o(frz)
  );

  bhc_bus_float u_float (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph2_en_i(ph2_en_i),
    .ack_i(ack), .float_o(flt)
  );

  assign hold_ack_o    = ack;
  assign bus_float_o   = flt;
  assign core_freeze_o = frz;

  // R5
  float_covers_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack) |-> flt);
  // R5
  no_stray_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt && !ack |-> !$past(ph2_en_i) || $past(ack));
endmodule

// File: tb/bus_hold_ctrl_test.sv
module bus_hold_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph1 = 1'b0, ph2 = 1'b0;
  logic hold_req = 1'b0, ready = 1'b1;
  logic [2:0] mstate = 3'd0;
  logic rd_cyc = 1'b1, cyc_end = 1'b0;
  logic ack_o, flt_o, frz_o;

  int checks = 0, fails = 0, ack_rises = 0;
  bit done = 0;

  // core stimulus program
  int mode_len = 3; bit mode_rd = 1; bit mode_halt = 0;
  int p = 3, st = 0, len = 3, prev_st = 0; bit prev_rd = 1;

  // reference model state
  bit q1, q2, m_latch, m_ack, m_flt, m_frz, m_pt3;
  bit s_ack, s_flt, s_frz;

  always #10 clk = ~clk;

  bus_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ph1_en_i(ph1), .ph2_en_i(ph2),
    .hold_req_i(hold_req), .ready_i(ready), .mstate_i(mstate),
    .rd_cyc_i(rd_cyc), .cyc_end_i(cyc_end),
    .hold_ack_o(ack_o), .bus_float_o(flt_o), .core_freeze_o(frz_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = 0; q2 = 0; m_latch = 0; m_ack = 0; m_flt = 0; m_frz = 0; m_pt3 = 0;
    end else begin
      bit r;
      r = q2; q2 = q1; q1 = hold_req;
      if (ph2) begin
        if (!r) m_latch = 0;
        else if (ready) m_latch = 1;
        m_flt = m_ack;
      end
      if (ph1) begin
        if (m_ack) m_ack = r;
        else if (m_latch && ((mstate == 2 && rd_cyc) || m_pt3 || mstate == 6)) m_ack = 1;
        if (!m_ack) m_frz = 0;
        else if (cyc_end || mstate == 6) m_frz = 1;
        m_pt3 = (mstate == 2) && !rd_cyc;
      end
    end
  end

  // monitor then core/phase drive, all at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(ack_o == m_ack, "R2/R3/R7 ack", ack_o, m_ack);
        chk(flt_o == m_flt, "R4 float", flt_o, m_flt);
        chk(frz_o == m_frz, "R6 freeze", frz_o, m_frz);
        if (ack_o && !s_ack) begin
          ack_rises++;
          chk(ph1, "R11 ack edge", ph1, 1);
          if (mstate == 6) chk(1, "R9", 1, 1);
          else chk((mstate == 2 && rd_cyc) || (prev_st == 2 && !prev_rd),
                   "R2/R3 ack point", mstate, 2);
        end
        if (!ack_o && s_ack) begin
          chk(!frz_o, "R7 freeze drop", frz_o, 0);
          chk(flt_o, "R5 float held", flt_o, 1);
        end
        if (flt_o && !s_flt) chk(ack_o && ph2, "R4 float rise", ack_o, 1);
        if (!flt_o && s_flt) chk(!ack_o && ph2, "R4 float fall", ack_o, 0);
        if (frz_o && !s_frz) chk(cyc_end || mstate == 6, "R6 freeze point", cyc_end, 1);
      end
      s_ack = ack_o; s_flt = flt_o; s_frz = frz_o;
      if (!rst_n) begin
        p = 3; ph1 = 0; ph2 = 0; st = 0; len = mode_len; cyc_end = 0;
        rd_cyc = mode_rd; mstate = 0;
      end else begin
        p = (p + 1) % 4;
        ph1 = (p == 0); ph2 = (p == 2);
        if (p == 0) begin
          prev_st = st; prev_rd = rd_cyc; cyc_end = 0;
          if (frz_o) begin
          end else if (st == 6) begin
            if (!mode_halt) begin st = 0; len = mode_len; rd_cyc = mode_rd; end
          end else if (st == len - 1) begin
            cyc_end = 1; len = mode_len; rd_cyc = mode_rd;
            st = mode_halt ? 6 : 0;
          end else st++;
          mstate = 3'(st);
        end
      end
    end
  end

  task automatic clks(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_ack(bit v, int max, string req);
    int i;
    for (i = 0; i < max; i++) begin
      @(negedge clk); #1;
      if (ack_o == v) break;
    end
    chk(ack_o == v, req, ack_o, v);
  endtask

  task automatic hold_cycle(int ln, bit rd, string req);
    mode_len = ln; mode_rd = rd;
    clks(40);
    hold_req = 1;
    wait_ack(1, 120, req);
    clks(40);
    hold_req = 0;
    wait_ack(0, 40, {req, " R7 release"});
    clks(6);
    chk(!flt_o, "R4 float off", flt_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    int base;
    clks(5);
    chk(!ack_o && !flt_o && !frz_o, "R10 reset", {ack_o, flt_o, frz_o}, 0);
    rst_n = 1;
    clks(20);
    // R8 short pulse between phase2 samples
    do begin @(negedge clk); #1; end while (p != 3);
    base = ack_rises;
    hold_req = 1; @(negedge clk); #1; hold_req = 0;
    clks(40);
    chk(ack_rises == base && !ack_o, "R8 pulse ignored", ack_rises - base, 0);
    // R1 ready low blocks
    ready = 0; hold_req = 1;
    clks(60);
    chk(!ack_o, "R1 ready low", ack_o, 0);
    ready = 1;
    wait_ack(1, 80, "R1 ack after ready");
    hold_req = 0;
    wait_ack(0, 40, "R7 release");
    clks(6);
    hold_cycle(3, 1, "R2 read3");
    hold_cycle(5, 1, "R6 read5");
    hold_cycle(4, 0, "R3 write4");
    hold_cycle(3, 0, "R3 write3");
    // R9 halt
    mode_len = 3; mode_rd = 1; mode_halt = 1;
    do begin @(negedge clk); #1; end while (st != 6);
    clks(8);
    hold_req = 1;
    wait_ack(1, 60, "R9 halt ack");
    chk(mstate == 6, "R9 in halt", mstate, 6);
    hold_req = 0;
    wait_ack(0, 40, "R9 release");
    clks(12);
    chk(mstate == 6 && !ack_o, "R9 back in halt", mstate, 6);
    mode_halt = 0;
    clks(20);
    // R10 reset during hold
    hold_req = 1;
    wait_ack(1, 120, "R10 setup");
    rst_n = 0; #1;
    chk(!ack_o && !flt_o && !frz_o, "R10 async reset", {ack_o, flt_o, frz_o}, 0);
    hold_req = 0;
    clks(4);
    rst_n = 1;
    clks(20);
    chk(!ack_o && !flt_o, "R10 idle after reset", ack_o, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule